// File: doc/BRIEF.md
# NOR Flash Toggle-Bit Completion Poller

This block watches an embedded program or erase operation inside a NOR flash and reports when it has ended. After a start pulse it keeps reading one status address in pairs of reads. It compares the toggle bit between the two reads of a pair and looks at the time-limit bit in the first read. If the toggle bit has stopped changing, the operation has finished. If it is still changing while the time-limit bit is set, the block reads one more pair before it reports a device error.

A separate read port lets the surrounding controller do the bus cycles. The poller raises a request with an address, and the controller answers with a valid strobe and the data word. A cycle budget given at start can end the polling with a timeout result. Setting the budget to all ones turns the timeout off. The outcome is held on a two-bit result port, and a one-cycle done strobe marks the cycle it appears.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_req_o` are low and `result_o` is 2'b00 (no result).
- R2: A start pulse while idle stores `addr_i` and `timeout_i`, sets `busy_o`, and clears `result_o` to 2'b00 in the next cycle. Every read goes to the stored address. A start pulse while busy is ignored.
- R3: `rd_req_o` stays high with a stable `rd_addr_o` until a cycle in which `rd_valid_i` is high, and that cycle completes the read. The reads of a pair follow each other with no check between them.
- R4: When bit 6 (the toggle bit) is equal in both words of a pair, polling ends with result 2'b01 (success).
- R5: When bit 6 differs and bit 5 (the time-limit bit) of the first word is clear, another pair is read.
- R6: When bit 6 differs and bit 5 of the first word is set, a confirmation pair is read. If that pair still toggles with bit 5 set in its first word, the result is 2'b10 (error). If it does not toggle, the result is success. If it toggles with bit 5 clear, normal polling resumes.
- R7: A timeout of zero ends the operation with result 2'b11 (timeout) without issuing any read.
- R8: Before each pair, if the clock cycles counted since start have reached the timeout, polling ends with result 2'b11.
- R9: A timeout of all ones disables the limit, so polling runs until success or error.
- R10: `done_o` is high for exactly one cycle, in the cycle `result_o` takes its final value. The result then holds until the next accepted start.
- R11: A `rd_valid_i` strobe while idle has no effect on `busy_o`, `done_o` or `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted only while idle) |
| addr_i | input | AW | Status address to poll |
| timeout_i | input | TW | Cycle budget; 0 = immediate timeout, all ones = no limit |
| rd_req_o | output | 1 | Read request to the flash bus controller |
| rd_addr_o | output | AW | Address of the requested read |
| rd_valid_i | input | 1 | Read data is valid this cycle |
| rd_data_i | input | DW | Status word returned by the flash |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle strobe when a result is written |
| result_o | output | 2 | 00 none, 01 success, 10 error, 11 timeout |

## Verification
The bench targets the confirmation pair. A one-read glitch on the time-limit bit must lead back into polling and end in success. A design that reports an error on any toggling confirmation pair would return 10 with too few reads. Status words change in their low bits on every read, so a design that compares whole words instead of the toggle bit never reports success. The bench also checks the all-ones budget against an operation longer than that budget, which catches a design that treats all ones as an ordinary limit. A zero budget must return timeout with no read. A start pulse arriving in mid-operation must not move the read address, and a stray valid strobe while idle must not produce a result.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_OK   = 2'b01,
        RES_ERR  = 2'b10,
        RES_TMO  = 2'b11
    } poll_res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FIRST,
        ST_SECOND
    } poll_st_e;

    typedef enum logic [1:0] {
        V_FINISH,
        V_AGAIN,
        V_CONFIRM,
        V_FAIL
    } verdict_e;

endpackage

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] LIM_OFF = '1;

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (count_q != CNT_MAX) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    always_comb begin
        if (limit_i == '0) begin
            expired_o = 1'b1;
        end else if (limit_i == LIM_OFF) begin
            expired_o = 1'b0;
        end else begin
            expired_o = (count_q >= limit_i);
        end
    end

    // R8: the elapsed count saturates instead of wrapping
    a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
    import nor_poll_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic [DW-1:0] first_word_i,
    input  logic [DW-1:0] second_word_i,
    input  logic          confirm_i,
    output verdict_e      verdict_o
);
    logic toggled;
    logic limit_hit;

    assign toggled   = first_word_i[TOG_BIT] ^ second_word_i[TOG_BIT];
    assign limit_hit = first_word_i[LIM_BIT];

    always_comb begin
        if (!toggled) begin
            verdict_o = V_FINISH;
        end else if (limit_hit) begin
            verdict_o = confirm_i ? V_FAIL : V_CONFIRM;
        end else begin
            verdict_o = V_AGAIN;
        end
    end

endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
    import nor_poll_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int TW      = 20,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] timeout_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    typedef struct packed {
        poll_st_e      st;
        logic [AW-1:0] addr;
        logic [TW-1:0] limit;
        logic [DW-1:0] first;
        logic          confirm;
        poll_res_e     res;
        logic          done;
    } poll_regs_t;

    poll_regs_t r_d, r_q;
    logic       timer_clear;
    logic       expired;
    verdict_e   verdict;

    nor_poll_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (timer_clear),
        .limit_i  (r_q.limit),
        .expired_o(expired)
    );

    nor_poll_judge #(.DW(DW), .TOG_BIT(TOG_BIT), .LIM_BIT(LIM_BIT)) u_judge (
        .first_word_i (r_q.first),
        .second_word_i(rd_data_i),
        .confirm_i    (r_q.confirm),
        .verdict_o    (verdict)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        timer_clear = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_CHECK;
                    r_d.addr    = addr_i;
                    r_d.limit   = timeout_i;
                    r_d.res     = RES_NONE;
                    r_d.confirm = 1'b0;
                    timer_clear = 1'b1;
                end
            end
            ST_CHECK: begin
                if (expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.res  = RES_TMO;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (rd_valid_i) begin
                    r_d.first = rd_data_i;
                    r_d.st    = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (rd_valid_i) begin
                    unique case (verdict)
                        V_FINISH: begin
                            r_d.st   = ST_IDLE;
                            r_d.res  = RES_OK;
                            r_d.done = 1'b1;
                        end
                        V_FAIL: begin
                            r_d.st   = ST_IDLE;
                            r_d.res  = RES_ERR;
                            r_d.done = 1'b1;
                        end
                        V_CONFIRM: begin
                            r_d.st      = ST_CHECK;
                            r_d.confirm = 1'b1;
                        end
                        default: begin
                            r_d.st      = ST_CHECK;
                            r_d.confirm = 1'b0;
                        end
                    endcase
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, limit: '0, first: '0,
                     confirm: 1'b0, res: RES_NONE, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign rd_req_o  = (r_q.st == ST_FIRST) || (r_q.st == ST_SECOND);
    assign rd_addr_o = r_q.addr;
    assign done_o    = r_q.done;
    assign result_o  = r_q.res;

    // R2: accepted start clears the result and makes the poller busy
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && result_o == RES_NONE && !done_o));

    // R3: an unanswered request stays up on the same address
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R4: equal toggle bit in a completed pair gives success next cycle
    a_r4_equal_is_success: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SECOND && rd_valid_i && rd_data_i[TOG_BIT] == r_q.first[TOG_BIT])
        |=> (done_o && result_o == RES_OK));

    // R7: zero budget ends two cycles after start with a timeout
    a_r7_zero_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && timeout_i == '0) |=> ##1 (done_o && result_o == RES_TMO));

    // R10: done is a single-cycle strobe
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: result holds while idle without a start
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));

    // R11: valid strobes while idle change nothing
    a_r11_idle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && rd_valid_i) |=> (!busy_o && !done_o));

endmodule

// File: tb/sim_nor_toggle_poller.sv
module sim_nor_toggle_poller;
    import nor_poll_pkg::*;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int LAT = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [TW-1:0] tmo = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          vld = 1'b0;
    logic          stray = 1'b0;
    logic          rd_valid;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done;
    logic [1:0]    result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign rd_valid = vld | stray;

    nor_toggle_poller #(.AW(AW), .DW(DW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .timeout_i(tmo),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // flash status model
    int            k = 0;
    int            tog_n = 0;
    int            d5_from = 0;
    int            d5_to = 0;
    logic [AW-1:0] cur_addr = '0;
    bit            pend = 0;
    int            cnt = 0;

    function automatic logic [DW-1:0] status_word(input int i);
        logic [DW-1:0] w;
        w = 16'h9A00 | DW'(i & 15);
        w[6] = (i < tog_n) ? i[0] : 1'b0;
        w[5] = (i >= d5_from && i < d5_to);
        return w;
    endfunction

    always @(negedge clk) begin
        if (vld) begin
            vld = 1'b0;
            pend = 0;
        end else if (pend) begin
            if (cnt == 0) begin
                // R2 / R3: every read targets the stored address
                chk(rd_addr == cur_addr && rd_req, "R2", "read address",
                    int'(rd_addr), int'(cur_addr));
                rd_data = status_word(k);
                k++;
                vld = 1'b1;
            end else begin
                cnt--;
            end
        end else if (rd_req && rst_n) begin
            pend = 1;
            cnt = LAT;
        end
    end

    // scoreboard
    typedef struct {
        logic [1:0] res;
        int         reads;
        string      req;
    } exp_t;
    exp_t sb[$];
    bit   low_next = 0;

    always @(negedge clk) begin
        if (low_next) begin
            chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
            low_next = 0;
        end
        if (done && rst_n) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.res, e.req, "result", int'(result), int'(e.res));
                if (e.reads >= 0)
                    chk(k == e.reads, e.req, "read count", k, e.reads);
            end
            low_next = 1;
        end
    end

    task automatic run(input logic [AW-1:0] a, input logic [TW-1:0] t,
                       input int tn, input int f5, input int e5,
                       input logic [1:0] eres, input int ereads, input string req,
                       input int intrude);
        exp_t e;
        @(negedge clk);
        k = 0; tog_n = tn; d5_from = f5; d5_to = e5; cur_addr = a;
        e.res = eres; e.reads = ereads; e.req = req;
        sb.push_back(e);
        start = 1'b1; addr = a; tmo = t;
        @(negedge clk);
        start = 1'b0; addr = ~a; tmo = '0;
        // R2: result cleared, busy set
        chk(result == RES_NONE && busy, "R2", "cleared on start", int'(result), 0);
        if (intrude > 0) begin
            repeat (intrude) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !rd_req, "R1", "idle outputs", int'({busy, done, rd_req}), 0);
        chk(result == RES_NONE, "R1", "reset result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: no toggling at all
        run(24'h000100, 8'd200, 0, 1000, 1000, RES_OK, 2, "R4", 0);
        // R5: toggles for three pairs, then stops; mid-run start must be ignored (R2)
        run(24'h012345, 8'd200, 6, 1000, 1000, RES_OK, 8, "R5", 9);
        // R6: time-limit bit persists while toggling -> error
        run(24'h0ABCDE, 8'd200, 1000, 2, 1000, RES_ERR, 6, "R6", 0);
        // R6: toggling stops in the confirmation pair -> success
        run(24'h000777, 8'd200, 4, 2, 1000, RES_OK, 6, "R6", 0);
        // R6: glitch of the time-limit bit -> polling resumes
        run(24'h000888, 8'd200, 8, 2, 3, RES_OK, 10, "R6", 0);
        // R7: zero budget, no read
        run(24'h000999, 8'd0, 1000, 1000, 1000, RES_TMO, 0, "R7", 0);
        // R8: short budget with a device that never finishes
        run(24'h000AAA, 8'd40, 1000, 1000, 1000, RES_TMO, -1, "R8", 0);
        // R8: budget shorter than the operation
        run(24'h000BBB, 8'd200, 150, 1000, 1000, RES_TMO, -1, "R8", 0);
        // R9: all-ones budget outlasts the same operation
        run(24'h000CCC, 8'hFF, 150, 1000, 1000, RES_OK, 152, "R9", 0);

        // R11: stray valid while idle
        @(negedge clk);
        rd_data = 16'h0040;
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        chk(!busy && !done, "R11", "idle after stray valid", int'({busy, done}), 0);
        @(negedge clk);
        chk(result == RES_OK, "R11", "result unchanged", int'(result), int'(RES_OK));
        chk(sb.size() == 0, "R10", "all results seen", sb.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule